// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a simple synchronous register bus and the serial shift engines of one asynchronous serial port channel. It keeps a control word with a module-enable bit and a self-clearing soft-reset bit, a one-byte transmit holding register and a two-entry receive queue. The enable bit drives a clock-enable output toward the serial engine. The soft-reset bit starts a short, fixed clearing sequence for the transfer control state and the status flags.

Software writes a byte to the transmit register while the transmit holding register is empty. The transmit engine sees a valid byte and acknowledges it with a take strobe. The receive engine pushes bytes into the queue, and software reads them back oldest first. Each read of the receive register removes one entry. Reading the receive register when the queue is empty returns the byte that was read last. A push into a full queue is discarded and raises a sticky overrun flag.

Top module: `uart_reg_if`

## Requirements
- R1: After a synchronous reset the control word reads 0x0000, `eng_clk_en`, `tx_valid`, `soft_rst` and `rx_overrun` are 0, `tx_empty` is 1, and `bus_rdata` is 0x0000.
- R2: Address 0 holds the control word. Bit 0 (enable) is read/write and drives `eng_clk_en` from the cycle after the write. Bits 15..2 always read 0. Address 3 reads 0x0000.
- R3: Writing the control word with bit 1 set raises `soft_rst` for exactly 2 cycles, starting the cycle after the write. Control bit 1 reads 1 during those cycles and 0 afterwards. Writing bit 1 as 0 starts nothing.
- R4: A soft reset empties the receive queue and clears the last-read byte to 0x00, clears the transmit holding register (`tx_empty` back to 1), and clears `rx_overrun`. It leaves the enable bit unchanged.
- R5: A write to address 1 while `tx_empty` is 1 loads bits 7..0 into the holding register. From the next cycle `tx_valid`=1, `tx_empty`=0 and `tx_data` equals the byte. Address 1 reads the byte in bits 7..0 with bits 15..8 at 0.
- R6: A write to address 1 while `tx_empty` is 0 is ignored, and the held byte is unchanged.
- R7: A `tx_take` pulse while `tx_valid` is 1 returns `tx_empty` to 1 on the next cycle, after which a new byte can be loaded.
- R8: Reads of address 2 return queued bytes oldest first in bits 7..0 with bits 15..8 at 0. The data appears on `bus_rdata` the cycle after the read strobe.
- R9: A read of address 2 with an empty queue returns the last byte read (0x00 if none since reset) and does not move the queue; the next pushed byte is returned by the next read.
- R10: A push while the queue holds 2 bytes and no read occurs is dropped and sets `rx_overrun`, which stays 1 until reset or soft reset. The stored bytes are unaffected.
- R11: A push and a read in the same cycle on a full queue both take effect, and `rx_overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 control, 1 transmit, 2 receive) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, valid the cycle after `bus_rd` |
| eng_clk_en | output | 1 | Clock enable toward the serial engine |
| soft_rst | output | 1 | Clearing pulse toward transfer control and flags |
| tx_data | output | 8 | Byte offered to the transmit engine |
| tx_valid | output | 1 | Holding register has a byte |
| tx_take | input | 1 | Transmit engine accepts the byte |
| tx_empty | output | 1 | Transmit-buffer-empty flag |
| rx_push | input | 1 | Receive engine delivers a byte |
| rx_data | input | 8 | Received byte |
| rx_full | output | 1 | Receive queue holds 2 bytes |
| rx_overrun | output | 1 | Sticky dropped-byte flag |

## Verification
Every result here is due exactly one clock edge after its stimulus. That holds for read data, enable, the transmit flags, queue contents and overrun. The one exception is the soft-reset pulse, which stays high for the two cycles after the control write. The bench drives each stimulus on a falling edge, lets one rising edge pass, and samples on the following falling edge, so each check reads the value from the first cycle it is due. For the soft-reset case the bench samples `soft_rst` on three consecutive falling edges and reads the control word while the pulse is high. This pins the pulse to two cycles.

// File: rtl/uart_regif_pkg.sv
// Package: shared register address codes and control bit positions for the
// serial port register front end. Assumes a 2-bit word address.
package uart_regif_pkg;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_TXBUF = 2'd1,
        RA_RXBUF = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SRST_BIT = 1;

endpackage

// File: rtl/uart_ctrl_reg.sv
// Module: control word storage. Holds the enable bit and runs the fixed
// length soft-reset countdown. Assumes wr_en is a single-cycle qualified
// write to the control address; only the two defined bits are passed in.
module uart_ctrl_reg #(
    parameter int SRST_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wbits,
    output logic       enable,
    output logic       srst_busy
);
    import uart_regif_pkg::*;

    localparam int CNT_W = $clog2(SRST_CYCLES + 1);

    logic [CNT_W-1:0] srst_cnt;

    // Enable bit: loaded on every control write, cleared by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= 1'b0;
        else if (wr_en)
            enable <= wbits[CTRL_EN_BIT];
    end

    // Soft-reset countdown: a write of 1 (re)loads it, otherwise it runs down to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            srst_cnt <= '0;
        else if (wr_en && wbits[CTRL_SRST_BIT])
            srst_cnt <= CNT_W'(SRST_CYCLES);
        else if (srst_cnt != '0)
            srst_cnt <= srst_cnt - 1'b1;
    end

    assign srst_busy = (srst_cnt != '0);

    p_srst_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wbits[CTRL_SRST_BIT]) |=> srst_busy);

    p_srst_zero_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_busy && !(wr_en && wbits[CTRL_SRST_BIT])) |=> !srst_busy);

    p_enable_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enable));

endmodule

// File: rtl/uart_tx_buffer.sv
// Module: one-byte transmit holding register. It loads only when empty,
// frees on take, and is cleared by the soft-reset window.
// Assumes take is only meaningful while valid is 1.
module uart_tx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic [DATA_W-1:0] data,
    output logic              valid
);

    // Holding register and its occupancy flag; clear has priority over traffic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
        end else if (clr) begin
            data  <= '0;
            valid <= 1'b0;
        end else if (valid) begin
            if (take)
                valid <= 1'b0;
        end else if (wr_en) begin
            data  <= wdata;
            valid <= 1'b1;
        end
    end

    p_txd_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !take && !clr) |=> (valid && $stable(data)));

    p_take_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && take && !clr) |=> !valid);

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && wr_en && !clr) |=> (valid && data == $past(wdata)));

    p_clr_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !valid);

endmodule

// File: rtl/uart_rx_fifo.sv
// Module: receive queue, oldest first, DEPTH entries. A pop on an empty
// queue returns the last popped byte. A push into a full queue with no
// pop is dropped and sets a sticky overrun flag. clr empties it.
module uart_rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic              overrun
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] last_q;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              pop_ok, push_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign head    = empty ? last_q : mem[rd_ptr];

    // One storage register per entry, written when the write pointer selects it.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[gi] <= '0;
            else if (!clr && push_ok && wr_ptr == PTR_W'(gi))
                mem[gi] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Last-read byte, returned on reads from an empty queue.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            last_q <= '0;
        else if (pop_ok)
            last_q <= mem[rd_ptr];
    end

    // Sticky overrun: a dropped push sets it; only reset or clear removes it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            overrun <= 1'b0;
        else if (push && !push_ok)
            overrun <= 1'b1;
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> overrun);

    p_full_swap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full && !overrun && !clr) |=> (full && !overrun));

    p_empty_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> (empty && $stable(head)));

    p_clr_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !overrun && head == '0));

endmodule

// File: rtl/uart_reg_if.sv
// Module: top of the serial port register front end. It decodes the bus,
// registers read data, and connects the control word, transmit holding
// register and receive queue. Assumes single-cycle read/write strobes and
// that the engines honour tx_valid and rx_full.
module uart_reg_if #(
    parameter int REG_W       = 16,
    parameter int DATA_W      = 8,
    parameter int RX_DEPTH    = 2,
    parameter int SRST_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              eng_clk_en,
    output logic              soft_rst,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_take,
    output logic              tx_empty,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_overrun
);
    import uart_regif_pkg::*;

    localparam int PAD_W = REG_W - DATA_W;

    reg_addr_e         addr;
    logic              ctl_wr, tx_wr, rx_pop;
    logic              enable_q, busy;
    logic [DATA_W-1:0] rx_head;
    logic              rx_empty;
    logic              unused_wdata_hi;

    assign addr            = reg_addr_e'(bus_addr);
    assign ctl_wr          = bus_wr && (addr == RA_CTRL);
    assign tx_wr           = bus_wr && (addr == RA_TXBUF);
    assign rx_pop          = bus_rd && (addr == RA_RXBUF);
    assign unused_wdata_hi = ^bus_wdata[REG_W-1:DATA_W];

    uart_ctrl_reg #(
        .SRST_CYCLES (SRST_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctl_wr),
        .wbits     (bus_wdata[1:0]),
        .enable    (enable_q),
        .srst_busy (busy)
    );

    uart_tx_buffer #(
        .DATA_W (DATA_W)
    ) u_txbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (busy),
        .wr_en (tx_wr),
        .wdata (bus_wdata[DATA_W-1:0]),
        .take  (tx_take),
        .data  (tx_data),
        .valid (tx_valid)
    );

    uart_rx_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (RX_DEPTH)
    ) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (busy),
        .push      (rx_push),
        .push_data (rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full),
        .overrun   (rx_overrun)
    );

    assign eng_clk_en = enable_q;
    assign soft_rst   = busy;
    assign tx_empty   = !tx_valid;

    // Registered read mux; data is presented the cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd) begin
            case (addr)
                RA_CTRL:  bus_rdata <= {{(REG_W-2){1'b0}}, busy, enable_q};
                RA_TXBUF: bus_rdata <= {{PAD_W{1'b0}}, tx_data};
                RA_RXBUF: bus_rdata <= {{PAD_W{1'b0}}, rx_head};
                default:  bus_rdata <= '0;
            endcase
        end
    end

    p_ctl_busy_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && addr == RA_CTRL && soft_rst) |=> bus_rdata[CTRL_SRST_BIT]);

    p_enable_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !ctl_wr) |=> (eng_clk_en == $past(eng_clk_en)));

    p_rx_empty_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_empty && rx_full));

endmodule

// File: tb/test_uart_reg_if.sv
// Bench: a vector table walked by one loop, then directed tests for
// reset, port-level flags, overrun, full-queue swap and soft reset.
module test_uart_reg_if;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        eng_clk_en, soft_rst, tx_valid, tx_empty, rx_full, rx_overrun;
    logic [7:0]  tx_data;
    logic        tx_take = 1'b0, rx_push = 1'b0;
    logic [7:0]  rx_data = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    uart_reg_if i_uart_reg_if (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .eng_clk_en (eng_clk_en),
        .soft_rst   (soft_rst),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_take    (tx_take),
        .tx_empty   (tx_empty),
        .rx_push    (rx_push),
        .rx_data    (rx_data),
        .rx_full    (rx_full),
        .rx_overrun (rx_overrun)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [1:0]  addr;
        logic [15:0] wd;
        logic        push;
        logic        take;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 4'd1},  // R1 control reads 0
        '{1'b1, 1'b0, 2'd0, 16'h0001, 1'b0, 1'b0, 16'h0000, 4'd2},  // R2 set enable
        '{1'b0, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0001, 4'd2},  // R2 enable reads back
        '{1'b1, 1'b0, 2'd0, 16'hFFFD, 1'b0, 1'b0, 16'h0000, 4'd2},  // R2 reserved ones, R3 bit1=0
        '{1'b0, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0001, 4'd3},  // R3 no reset started
        '{1'b1, 1'b0, 2'd1, 16'h01A5, 1'b0, 1'b0, 16'h0000, 4'd5},  // R5 load byte
        '{1'b0, 1'b1, 2'd1, 16'h0000, 1'b0, 1'b0, 16'h00A5, 4'd5},  // R5 read back
        '{1'b1, 1'b0, 2'd1, 16'h003C, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6 write while full
        '{1'b0, 1'b1, 2'd1, 16'h0000, 1'b0, 1'b0, 16'h00A5, 4'd6},  // R6 unchanged
        '{1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 16'h0000, 4'd7},  // R7 take
        '{1'b1, 1'b0, 2'd1, 16'h003C, 1'b0, 1'b0, 16'h0000, 4'd7},  // R7 reload
        '{1'b0, 1'b1, 2'd1, 16'h0000, 1'b0, 1'b0, 16'h003C, 4'd7},  // R7 new byte
        '{1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 16'h0000, 4'd7},  // R7 take again
        '{1'b0, 1'b0, 2'd0, 16'h0011, 1'b1, 1'b0, 16'h0000, 4'd8},  // R8 push 11
        '{1'b0, 1'b0, 2'd0, 16'h0022, 1'b1, 1'b0, 16'h0000, 4'd8},  // R8 push 22
        '{1'b0, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b0, 16'h0011, 4'd8},  // R8 oldest first
        '{1'b0, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b0, 16'h0022, 4'd8},  // R8 second
        '{1'b0, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b0, 16'h0022, 4'd9},  // R9 empty repeats last
        '{1'b0, 1'b0, 2'd0, 16'h0033, 1'b1, 1'b0, 16'h0000, 4'd9},  // R9 push 33
        '{1'b0, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b0, 16'h0033, 4'd9},  // R9 pointers intact
        '{1'b0, 1'b1, 2'd3, 16'h0000, 1'b0, 1'b0, 16'h0000, 4'd2}   // R2 unused address
    };

    // Drive one cycle of stimulus from a falling edge to the next.
    task automatic step(input logic wr, input logic rd, input logic [1:0] a,
                        input logic [15:0] wd, input logic push, input logic take);
        bus_wr    = wr;
        bus_rd    = rd;
        bus_addr  = a;
        bus_wdata = wd;
        rx_push   = push;
        rx_data   = wd[7:0];
        tx_take   = take;
        @(negedge clk);
        bus_wr  = 1'b0;
        bus_rd  = 1'b0;
        rx_push = 1'b0;
        tx_take = 1'b0;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state at the ports
        check("R1 eng_clk_en", 16'(eng_clk_en), 16'h0);
        check("R1 tx_empty",   16'(tx_empty),   16'h1);
        check("R1 tx_valid",   16'(tx_valid),   16'h0);
        check("R1 soft_rst",   16'(soft_rst),   16'h0);
        check("R1 rx_overrun", 16'(rx_overrun), 16'h0);
        check("R1 bus_rdata",  bus_rdata,       16'h0);

        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].wd, VECS[i].push, VECS[i].take);
            if (VECS[i].rd)
                check($sformatf("R%0d vector %0d", VECS[i].req, i), bus_rdata, VECS[i].exp);
        end

        // R2 enable output
        check("R2 eng_clk_en", 16'(eng_clk_en), 16'h1);

        // R5 port view of a load, R7 take frees it
        step(1'b1, 1'b0, 2'd1, 16'h005A, 1'b0, 1'b0);
        check("R5 tx_valid", 16'(tx_valid), 16'h1);
        check("R5 tx_empty", 16'(tx_empty), 16'h0);
        check("R5 tx_data",  16'(tx_data),  16'h005A);
        step(1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1);
        check("R7 tx_empty", 16'(tx_empty), 16'h1);
        check("R7 tx_valid", 16'(tx_valid), 16'h0);

        // R10 overrun on third push
        step(1'b0, 1'b0, 2'd0, 16'h0041, 1'b1, 1'b0);
        step(1'b0, 1'b0, 2'd0, 16'h0042, 1'b1, 1'b0);
        check("R10 full", 16'(rx_full), 16'h1);
        check("R10 no overrun yet", 16'(rx_overrun), 16'h0);
        step(1'b0, 1'b0, 2'd0, 16'h0043, 1'b1, 1'b0);
        check("R10 overrun set", 16'(rx_overrun), 16'h1);
        step(1'b0, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b0);
        check("R10 first kept", bus_rdata, 16'h0041);
        step(1'b0, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b0);
        check("R10 second kept", bus_rdata, 16'h0042);
        step(1'b0, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b0);
        check("R10 dropped byte absent", bus_rdata, 16'h0042);
        check("R10 overrun sticky", 16'(rx_overrun), 16'h1);

        // R3/R4 soft reset with queue and transmit holding register occupied
        step(1'b0, 1'b0, 2'd0, 16'h0077, 1'b1, 1'b0);
        step(1'b1, 1'b0, 2'd1, 16'h0099, 1'b0, 1'b0);
        check("R4 tx loaded before", 16'(tx_empty), 16'h0);
        step(1'b1, 1'b0, 2'd0, 16'h0003, 1'b0, 1'b0);
        check("R3 soft_rst cycle 1", 16'(soft_rst), 16'h1);
        step(1'b0, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0);
        check("R3 busy bit reads 1", bus_rdata, 16'h0003);
        check("R3 soft_rst cycle 2", 16'(soft_rst), 16'h1);
        step(1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0);
        check("R3 soft_rst ends", 16'(soft_rst), 16'h0);
        step(1'b0, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0);
        check("R3 busy bit cleared", bus_rdata, 16'h0001);
        check("R4 enable kept", 16'(eng_clk_en), 16'h1);
        check("R4 tx_empty", 16'(tx_empty), 16'h1);
        check("R4 overrun cleared", 16'(rx_overrun), 16'h0);
        step(1'b0, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b0);
        check("R4 queue emptied", bus_rdata, 16'h0000);

        // R11 push and read together on a full queue
        step(1'b0, 1'b0, 2'd0, 16'h0001, 1'b1, 1'b0);
        step(1'b0, 1'b0, 2'd0, 16'h0002, 1'b1, 1'b0);
        step(1'b0, 1'b1, 2'd2, 16'h0003, 1'b1, 1'b0);
        check("R11 oldest read", bus_rdata, 16'h0001);
        check("R11 no overrun", 16'(rx_overrun), 16'h0);
        check("R11 still full", 16'(rx_full), 16'h1);
        step(1'b0, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b0);
        check("R11 second", bus_rdata, 16'h0002);
        step(1'b0, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b0);
        check("R11 pushed byte kept", bus_rdata, 16'h0003);

        // R3 zero write leaves soft reset idle; R2 enable clears
        step(1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0);
        check("R3 zero write no pulse", 16'(soft_rst), 16'h0);
        check("R2 enable cleared", 16'(eng_clk_en), 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule